// File: doc/BRIEF.md
# Interrupt Source Router

The block collects sixteen already-conditioned interrupt requests and steers each one to one of up to eight processor interrupt lines. Every source has a four-bit routing field that holds a three-bit target line number and an enable bit. Each source also has a pending latch: a source sets it, and software clears it with a write-one-to-clear register. Each processor line has its own output gate. Software programs the block through a plain 32-bit register port. A write takes effect at the clock edge that samples it. Read data appears on the edge after the read strobe.

A processor line is raised when its gate is open and at least one source is pending, enabled and routed to it. Software finds the cause in a per-line status view. That view shows every pending source routed to the line, enabled or not. Register port accesses are plain strobes that always complete, so the port has no back-pressure. The source inputs are sampled every cycle, so no stream handshake applies to them either.

Top module: `irq_router_top`

## Requirements
- R1: After reset every routing field, every gate bit and every pending latch is zero, every status read returns 0 and `irq_out` is 0.
- R2: Routing word at address 0x00 holds sources 0 to 7, and the word at 0x04 holds sources 8 to 15. Source k occupies bits [4j+3:4j] of its word, where j = k mod 8. In that nibble, bits [2:0] give the target line and bit 3 is the enable. Both words read back exactly as written.
- R3: The gate word at 0x08 keeps only bits [16+n] for lines n = 0 to 7. All its other bits read as 0, and writes to them are dropped.
- R4: `irq_out[n]` is 1 exactly when gate bit n is set and some source is pending, enabled and targeted at line n. It follows changes in latch, routing or gate state in the same cycle that the state changes.
- R5: A source input that is 1 at a clock edge sets that source's pending latch from that edge on. The latch stays set after the input returns to 0.
- R6: A write to 0x0C clears the pending latch of every source whose data bit is 1. A source that is active in the same cycle keeps its latch set, because the set wins. Zero bits change nothing, and reads of 0x0C return 0.
- R7: The status word at 0x10+4m shows, for line 2m in bits [15:0] and for line 2m+1 in bits [31:16], bit k set when source k is pending and targeted at that line. The enable bit does not affect it.
- R8: A disabled source still latches pending but never raises a line. Enabling it later while it is still pending raises its line.
- R9: A read strobe loads `bus_rdata` at the next edge. Unmapped addresses return 0. `bus_rdata` holds its value while no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 16 | Conditioned interrupt requests, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_out | output | 8 | Processor interrupt lines |

## Verification
A wrong routing field shows up on the wrong `irq_out` bit, and in the wrong half of a status word, in the cycle after the offending write. A pending latch stuck at 1 keeps a line raised after the clear write. A latch that failed to set leaves the line low one edge after the source pulse. The cases that discriminate are the same-cycle set and clear race, the line gated off while pending, and the source that is disabled yet pending. In each of these a latch error and a steering error show different port values.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int DATA_W = 32;
  localparam int NIB_W  = 4;
  localparam int TGT_W  = 3;
  localparam int GATE_LSB = 16;

  typedef struct packed {
    logic             en;
    logic [TGT_W-1:0] tgt;
  } route_t;
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_OUT = 8,
  parameter int ADDR_W  = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  output route_t [NUM_SRC-1:0]       route_q,
  output logic [NUM_OUT-1:0]         gate_q
);
  localparam int SPW      = DATA_W / NIB_W;
  localparam int N_WORDS  = NUM_SRC / SPW;
  localparam int GATE_ADR = N_WORDS * 4;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_field
    localparam int WRD  = s / SPW;
    localparam int SLOT = s % SPW;
    always_ff @(posedge clk) begin
      if (!rst_n)
        route_q[s] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(WRD * 4))
        route_q[s] <= wr_data[SLOT*NIB_W +: NIB_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      gate_q <= '0;
    else if (wr_en && wr_addr == ADDR_W'(GATE_ADR))
      gate_q <= wr_data[GATE_LSB +: NUM_OUT];
  end

  // R2 / R3: configuration changes only through a write
  a_r2_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(route_q) && $stable(gate_q)));
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               clr_stb,
  input  logic [NUM_SRC-1:0] clr_mask,
  output logic [NUM_SRC-1:0] pend_q
);
  logic [NUM_SRC-1:0] drop;
  assign drop = clr_stb ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~drop) | src_in;
  end

  a_r5_src_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (src_in != '0) |=> ((pend_q & $past(src_in)) == $past(src_in)));

  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && ((clr_mask & ~src_in) != '0)) |=>
      ((pend_q & $past(clr_mask & ~src_in)) == '0));

  a_r6_hold_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_stb |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/irq_out_mux.sv
module irq_out_mux
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_OUT = 8
) (
  input  route_t [NUM_SRC-1:0]             route,
  input  logic [NUM_SRC-1:0]               pend,
  input  logic [NUM_OUT-1:0]               gate,
  output logic [NUM_OUT-1:0][NUM_SRC-1:0]  stat,
  output logic [NUM_OUT-1:0]               irq_out
);
  logic [NUM_SRC-1:0] en_vec;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_en
    assign en_vec[s] = route[s].en;
  end

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_line
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_hit
      assign stat[n][s] = pend[s] && (route[s].tgt == TGT_W'(n));
    end
    assign irq_out[n] = gate[n] && |(stat[n] & en_vec);
  end
endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_OUT = 8,
  parameter int ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_OUT-1:0] irq_out
);
  localparam int SPW       = DATA_W / NIB_W;
  localparam int N_WORDS   = NUM_SRC / SPW;
  localparam int GATE_ADR  = N_WORDS * 4;
  localparam int CLR_ADR   = GATE_ADR + 4;
  localparam int STAT_ADR  = CLR_ADR + 4;
  localparam int N_STAT    = (NUM_OUT + 1) / 2;
  localparam int HALF      = DATA_W / 2;

  route_t [NUM_SRC-1:0]            route_q;
  logic [NUM_OUT-1:0]              gate_q;
  logic [NUM_SRC-1:0]              pend_q;
  logic [NUM_OUT-1:0][NUM_SRC-1:0] stat;
  logic                            clr_stb;
  logic [DATA_W-1:0]               rd_word;

  assign clr_stb = bus_wr && (bus_addr == ADDR_W'(CLR_ADR));

  irq_route_regs #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .route_q(route_q), .gate_q(gate_q));

  irq_pend_bank #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .clr_stb(clr_stb),
    .clr_mask(bus_wdata[NUM_SRC-1:0]), .pend_q(pend_q));

  irq_out_mux #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT)) u_mux (
    .route(route_q), .pend(pend_q), .gate(gate_q),
    .stat(stat), .irq_out(irq_out));

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < N_WORDS; w++)
      if (bus_addr == ADDR_W'(w * 4))
        rd_word = route_q[w*SPW +: SPW];
    if (bus_addr == ADDR_W'(GATE_ADR))
      rd_word[GATE_LSB +: NUM_OUT] = gate_q;
    for (int m = 0; m < N_STAT; m++) begin
      if (bus_addr == ADDR_W'(STAT_ADR + 4 * m)) begin
        rd_word[NUM_SRC-1:0] = stat[2*m];
        if (2 * m + 1 < NUM_OUT)
          rd_word[HALF +: NUM_SRC] = stat[2*m+1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/irq_router_top_bench.sv
`timescale 1ns/1ps
module irq_router_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_in = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_out;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_router_top u_irq_router_top (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic pulse(logic [15:0] s);
    @(negedge clk); src_in = s;
    @(negedge clk); src_in = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq_out", {24'd0, irq_out}, 32'd0);
    rd(6'h00, d); chk("R1 route0", d, 32'd0);
    rd(6'h04, d); chk("R1 route1", d, 32'd0);
    rd(6'h08, d); chk("R1 gate", d, 32'd0);
    rd(6'h10, d); chk("R1 stat0", d, 32'd0);
  endtask

  task automatic t_route_gate;
    logic [31:0] d;
    wr(6'h00, 32'hFEDC_BA98); rd(6'h00, d); chk("R2 word0", d, 32'hFEDC_BA98);
    wr(6'h04, 32'h0123_4567); rd(6'h04, d); chk("R2 word1", d, 32'h0123_4567);
    wr(6'h08, 32'hFFFF_FFFF); rd(6'h08, d); chk("R3 gate mask", d, 32'h00FF_0000);
    wr(6'h08, 32'h0); wr(6'h00, 32'h0); wr(6'h04, 32'h0);
    wr(6'h0C, 32'hFFFF);
  endtask

  task automatic t_latch_out;
    wr(6'h00, 32'h0000_0D00);  // source 2 -> line 5, enabled
    wr(6'h08, 32'h0020_0000);
    pulse(16'h0004);
    chk("R5 latch raises line", {24'd0, irq_out}, 32'h20);
    @(negedge clk);
    chk("R5 latch holds", {24'd0, irq_out}, 32'h20);
    wr(6'h08, 32'h0);
    chk("R4 gate off", {24'd0, irq_out}, 32'h0);
    wr(6'h08, 32'h0020_0000);
    chk("R4 gate on", {24'd0, irq_out}, 32'h20);
  endtask

  task automatic t_status_disabled;
    logic [31:0] d;
    wr(6'h04, 32'h0000_0040);  // source 9 -> line 4, disabled
    pulse(16'h0200);
    rd(6'h18, d); chk("R7 status lines 4/5", d, 32'h0004_0200);
    wr(6'h08, 32'h0030_0000);
    chk("R8 disabled no line", {24'd0, irq_out}, 32'h20);
    wr(6'h04, 32'h0000_00C0);
    chk("R8 enable pending", {24'd0, irq_out}, 32'h30);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr(6'h0C, 32'h0000_0004);
    chk("R6 clear src2", {24'd0, irq_out}, 32'h10);
    rd(6'h18, d); chk("R6 status after clear", d, 32'h0000_0200);
    wr(6'h0C, 32'h0);
    rd(6'h18, d); chk("R6 zero bits no effect", d, 32'h0000_0200);
    rd(6'h0C, d); chk("R6 clear reads zero", d, 32'h0);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    @(negedge clk);
    src_in = 16'h0200; bus_wr = 1'b1; bus_addr = 6'h0C; bus_wdata = 32'h0200;
    @(negedge clk);
    src_in = '0; bus_wr = 1'b0;
    rd(6'h18, d); chk("R6 set wins", d, 32'h0000_0200);
    wr(6'h0C, 32'h0200);
    chk("R6 cleared line low", {24'd0, irq_out}, 32'h0);
    rd(6'h18, d); chk("R6 status empty", d, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(6'h04, d);
    rd(6'h3C, d); chk("R9 unmapped", d, 32'h0);
    rd(6'h04, d); chk("R9 route readback", d, 32'h0000_00C0);
    repeat (3) @(negedge clk);
    chk("R9 rdata held", bus_rdata, 32'h0000_00C0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_route_gate();
    t_latch_out();
    t_status_disabled();
    t_clear();
    t_set_wins();
    t_unmapped();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule